// File: doc/BRIEF.md
# Interrupt Acceptance and Status-Flag Update Unit

This block decides, once per clock, whether a pending interrupt request is taken, and when it is, updates the processor status flags that govern later acceptance. It holds three pieces of state: a maskable-enable bit, a stack-select bit and a priority-level field. It arbitrates between a maskable request that carries a priority level, a non-maskable request, and a software-interrupt request that carries a number.

When a request is taken, the block raises a single-cycle acknowledge and reports which source won and its number. It also presents the flag word as it stood before the update, so that neighbouring logic can push it to the stack. Vector fetch and stacking are done by neighbouring logic. A restore input reloads the whole flag word, which models a return from an interrupt routine.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, `flags` reads 0 (maskable-enable 0, stack-select 0, level 0) and `ack` is 0.
- R2: A maskable request is never acknowledged while the maskable-enable bit (`flags[0]`) is 0.
- R3: A maskable request is acknowledged only when `mask_lvl` is strictly greater than the current level field (`flags[PRIO_W+1:2]`). An equal level is refused.
- R4: Every acknowledgement clears the maskable-enable bit.
- R5: Accepting a maskable request loads the level field with `mask_lvl`, and `ack_num` reports that level, zero-extended. Software and non-maskable acceptance leave the level field unchanged.
- R6: The stack-select bit (`flags[1]`) is cleared on maskable and non-maskable acceptance. It is also cleared on software acceptance with a number below `SW_LOW_LIMIT` (default 32). A software number of `SW_LOW_LIMIT` or above leaves it unchanged.
- R7: Software and non-maskable requests are accepted whatever the maskable-enable bit and the level field hold.
- R8: When several requests are pending in one cycle, only one is acknowledged. Non-maskable wins first, then software, then maskable.
- R9: A request sampled at a rising edge produces `ack` high for the cycle after that edge. In that cycle `flags` already shows the update, and `saved_flags` shows the word from before the edge. `ack_src` is 1 for maskable, 2 for software and 3 for non-maskable. `ack_num` is the software number, the maskable level, or 0 for non-maskable.
- R10: `restore_req` loads the flag word from `restore_word` at the next edge. The layout is bit 0 maskable-enable, bit 1 stack-select, bits `PRIO_W+1:2` level. Any request in that same cycle is dropped without acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_req | input | 1 | Maskable request pending |
| mask_lvl | input | PRIO_W | Priority level of the maskable request |
| nmi_req | input | 1 | Non-maskable request pending |
| soft_req | input | 1 | Software interrupt request (one-cycle pulse) |
| soft_num | input | NUM_W | Software interrupt number |
| restore_req | input | 1 | Reload the flag word |
| restore_word | input | PRIO_W+2 | Flag word to reload |
| ack | output | 1 | One-cycle acknowledge |
| ack_src | output | 2 | Accepted source code |
| ack_num | output | NUM_W | Accepted number or level |
| saved_flags | output | PRIO_W+2 | Flag word before the update |
| flags | output | PRIO_W+2 | Current flag word |

## Verification
The assertions assume that software requests are single-cycle pulses and that no request is held through reset. They also assume that a held non-maskable request is meant to be taken on every cycle it stays high. The stimulus drives each request for exactly one cycle and releases it before the next. It keeps every input low while reset is applied. It raises a non-maskable request for two consecutive cycles only in the test that checks back-to-back acceptance. Level and number values are chosen around the boundaries that matter: the level equal to the held one, the top level, and numbers 31 and 32.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_MASK = 2'd1,
      SRC_SOFT = 2'd2,
      SRC_NMI  = 2'd3
   } irq_src_e;

   localparam int BIT_IEN   = 0;
   localparam int BIT_SSEL  = 1;
   localparam int LVL_LSB   = 2;

endpackage

// File: rtl/irq_src_arbiter.sv
module irq_src_arbiter
   import irq_accept_pkg::*;
#(
   parameter int PRIO_W       = 3,
   parameter int NUM_W        = 6,
   parameter int SW_LOW_LIMIT = 32
) (
   input  logic              mask_req,
   input  logic [PRIO_W-1:0] mask_lvl,
   input  logic              nmi_req,
   input  logic              soft_req,
   input  logic [NUM_W-1:0]  soft_num,
   input  logic              restore_req,
   input  logic              cur_ien,
   input  logic [PRIO_W-1:0] cur_lvl,
   output logic              take,
   output irq_src_e          take_src,
   output logic [NUM_W-1:0]  take_num,
   output logic              clr_ssel,
   output logic              load_lvl
);

   localparam int FULL_RANGE = 2 ** NUM_W;

   logic pick_nmi;
   logic pick_soft;
   logic pick_mask;
   logic mask_ok;
   logic soft_low;

   // software number below the stack-select limit
   generate
      if (SW_LOW_LIMIT >= FULL_RANGE) begin : g_low_all
         assign soft_low = 1'b1;
      end else if (SW_LOW_LIMIT <= 0) begin : g_low_none
         assign soft_low = 1'b0;
      end else begin : g_low_cmp
         localparam logic [NUM_W:0] LIM = SW_LOW_LIMIT[NUM_W:0];
         assign soft_low = ({1'b0, soft_num} < LIM);
      end
   endgenerate

   assign mask_ok   = mask_req & cur_ien & (mask_lvl > cur_lvl);
   assign pick_nmi  = ~restore_req & nmi_req;
   assign pick_soft = ~restore_req & ~nmi_req & soft_req;
   assign pick_mask = ~restore_req & ~nmi_req & ~soft_req & mask_ok;

   assign take     = pick_nmi | pick_soft | pick_mask;
   assign load_lvl = pick_mask;
   assign clr_ssel = pick_nmi | pick_mask | (pick_soft & soft_low);

   always_comb begin
      take_src = SRC_NONE;
      take_num = '0;
      if (pick_nmi) begin
         take_src = SRC_NMI;
      end else if (pick_soft) begin
         take_src = SRC_SOFT;
         take_num = soft_num;
      end else if (pick_mask) begin
         take_src = SRC_MASK;
         take_num = NUM_W'(mask_lvl);
      end
   end

   // R8: at most one winner per cycle
   always_comb begin
      a_r8_one_winner : assert ($onehot0({pick_nmi, pick_soft, pick_mask}))
         else $error("more than one source selected");
   end

endmodule

// File: rtl/irq_flag_state.sv
module irq_flag_state
   import irq_accept_pkg::*;
#(
   parameter int PRIO_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              clr_ssel,
   input  logic              load_lvl,
   input  logic [PRIO_W-1:0] new_lvl,
   input  logic              restore_req,
   input  logic [PRIO_W+1:0] restore_word,
   output logic [PRIO_W+1:0] flag_word
);

   logic              ien_q;
   logic              ssel_q;
   logic [PRIO_W-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= 1'b0;
         ssel_q <= 1'b0;
         lvl_q  <= '0;
      end else if (restore_req) begin
         ien_q  <= restore_word[BIT_IEN];
         ssel_q <= restore_word[BIT_SSEL];
         lvl_q  <= restore_word[LVL_LSB +: PRIO_W];
      end else if (take) begin
         ien_q <= 1'b0;
         if (clr_ssel) ssel_q <= 1'b0;
         if (load_lvl) lvl_q  <= new_lvl;
      end
   end

   always_comb begin
      flag_word                      = '0;
      flag_word[BIT_IEN]             = ien_q;
      flag_word[BIT_SSEL]            = ssel_q;
      flag_word[LVL_LSB +: PRIO_W]   = lvl_q;
   end

   // R4: the enable bit never survives an acceptance
   a_r4_ien_cleared : assert property (@(posedge clk) disable iff (!rst_n)
      (take && !restore_req) |=> !ien_q)
      else $error("enable bit still set after acceptance");

   // R10: restore loads the supplied word
   a_r10_restore_load : assert property (@(posedge clk) disable iff (!rst_n)
      restore_req |=> (flag_word == $past(restore_word)))
      else $error("restore did not load the word");

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
   import irq_accept_pkg::*;
#(
   parameter int PRIO_W       = 3,
   parameter int NUM_W        = 6,
   parameter int SW_LOW_LIMIT = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_req,
   input  logic [PRIO_W-1:0] mask_lvl,
   input  logic              nmi_req,
   input  logic              soft_req,
   input  logic [NUM_W-1:0]  soft_num,
   input  logic              restore_req,
   input  logic [PRIO_W+1:0] restore_word,
   output logic              ack,
   output logic [1:0]        ack_src,
   output logic [NUM_W-1:0]  ack_num,
   output logic [PRIO_W+1:0] saved_flags,
   output logic [PRIO_W+1:0] flags
);

   localparam int FLAG_W = PRIO_W + 2;

   // elaboration-time parameter checks
   generate
      if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
         $error("PRIO_W must be 1..8");
      end
      if (NUM_W < PRIO_W || NUM_W > 16) begin : g_bad_num
         $error("NUM_W must be at least PRIO_W and at most 16");
      end
   endgenerate

   logic              take;
   irq_src_e          take_src;
   logic [NUM_W-1:0]  take_num;
   logic              clr_ssel;
   logic              load_lvl;
   logic [FLAG_W-1:0] flag_word;
   logic              run_q;

   irq_src_arbiter #(
      .PRIO_W      (PRIO_W),
      .NUM_W       (NUM_W),
      .SW_LOW_LIMIT(SW_LOW_LIMIT)
   ) u_arb (
      .mask_req   (mask_req),
      .mask_lvl   (mask_lvl),
      .nmi_req    (nmi_req),
      .soft_req   (soft_req),
      .soft_num   (soft_num),
      .restore_req(restore_req),
      .cur_ien    (flag_word[BIT_IEN]),
      .cur_lvl    (flag_word[LVL_LSB +: PRIO_W]),
      .take       (take),
      .take_src   (take_src),
      .take_num   (take_num),
      .clr_ssel   (clr_ssel),
      .load_lvl   (load_lvl)
   );

   irq_flag_state #(
      .PRIO_W(PRIO_W)
   ) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (take),
      .clr_ssel    (clr_ssel),
      .load_lvl    (load_lvl),
      .new_lvl     (mask_lvl),
      .restore_req (restore_req),
      .restore_word(restore_word),
      .flag_word   (flag_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack         <= 1'b0;
         ack_src     <= SRC_NONE;
         ack_num     <= '0;
         saved_flags <= '0;
         run_q       <= 1'b0;
      end else begin
         run_q <= 1'b1;
         ack   <= take;
         if (take) begin
            ack_src     <= take_src;
            ack_num     <= take_num;
            saved_flags <= flag_word;
         end
      end
   end

   assign flags = flag_word;

   // R2: maskable acceptance only with enable bit set
   a_r2_enable_needed : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_src == SRC_MASK) |-> saved_flags[BIT_IEN])
      else $error("maskable taken with enable clear");

   // R3: strictly greater level
   a_r3_strict_level : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_src == SRC_MASK) |->
         (ack_num[PRIO_W-1:0] > saved_flags[LVL_LSB +: PRIO_W]))
      else $error("maskable taken without higher level");

   // R5: level field follows the accepted level
   a_r5_level_load : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_src == SRC_MASK) |->
         (flags[LVL_LSB +: PRIO_W] == ack_num[PRIO_W-1:0]))
      else $error("level field not loaded");

   // R6: high software numbers keep stack-select
   a_r6_ssel_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_src == SRC_SOFT && ({1'b0, ack_num} >= (NUM_W+1)'(SW_LOW_LIMIT))) |->
         (flags[BIT_SSEL] == saved_flags[BIT_SSEL]))
      else $error("stack-select changed on high software number");

   // R8: non-maskable wins
   a_r8_nmi_first : assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(nmi_req) && !$past(restore_req)) |-> (ack && ack_src == SRC_NMI))
      else $error("non-maskable request not taken first");

   // R9: saved word is the word from before the edge
   a_r9_saved_word : assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && ack) |-> (saved_flags == $past(flags)))
      else $error("saved flag word mismatch");

   // R10: restore cycle produces no acknowledge
   a_r10_no_ack_on_restore : assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(restore_req)) |-> !ack)
      else $error("acknowledge during restore");

endmodule

// File: tb/test_irq_accept_ctrl.sv
`timescale 1ns/1ps
module test_irq_accept_ctrl;

   localparam int PRIO_W = 3;
   localparam int NUM_W  = 6;
   localparam int FW     = PRIO_W + 2;
   localparam int NV     = 22;

   typedef struct packed {
      logic [3:0]        rq;
      logic              rv;
      logic [FW-1:0]     rw;
      logic              mr;
      logic [PRIO_W-1:0] mp;
      logic              nr;
      logic              sr;
      logic [NUM_W-1:0]  sn;
      logic              ea;
      logic [1:0]        es;
      logic [NUM_W-1:0]  en;
      logic [FW-1:0]     esv;
      logic [FW-1:0]     ef;
   } vec_t;

   function automatic vec_t mk(input int rq, input int rv, input int rw, input int mr,
                               input int mp, input int nr, input int sr, input int sn,
                               input int ea, input int es, input int en, input int esv,
                               input int ef);
      vec_t v;
      v.rq = 4'(rq);  v.rv = 1'(rv);  v.rw = FW'(rw);  v.mr = 1'(mr);
      v.mp = PRIO_W'(mp); v.nr = 1'(nr); v.sr = 1'(sr); v.sn = NUM_W'(sn);
      v.ea = 1'(ea);  v.es = 2'(es);  v.en = NUM_W'(en); v.esv = FW'(esv);
      v.ef = FW'(ef);
      return v;
   endfunction

   // flag word: bit0 enable, bit1 stack-select, bits4:2 level
   localparam vec_t TBL [NV] = '{
      mk( 2, 0, 0,    1,5, 0,0, 0,  0,0, 0, 0,    5'h00), // R2 enable clear
      mk(10, 1, 5'h0B,1,7, 0,0, 0,  0,0, 0, 0,    5'h0B), // R10 restore wins
      mk( 3, 0, 0,    1,2, 0,0, 0,  0,0, 0, 0,    5'h0B), // R3 equal refused
      mk( 5, 0, 0,    1,3, 0,0, 0,  1,1, 3, 5'h0B,5'h0C), // R5 taken
      mk( 2, 0, 0,    1,7, 0,0, 0,  0,0, 0, 0,    5'h0C), // R2 blocked after take
      mk(10, 1, 5'h03,0,0, 0,0, 0,  0,0, 0, 0,    5'h03),
      mk( 6, 0, 0,    0,0, 0,1,40,  1,2,40, 5'h03,5'h02), // R6 high number
      mk(10, 1, 5'h03,0,0, 0,0, 0,  0,0, 0, 0,    5'h03),
      mk( 6, 0, 0,    0,0, 0,1,31,  1,2,31, 5'h03,5'h00), // R6 number 31
      mk(10, 1, 5'h1E,0,0, 0,0, 0,  0,0, 0, 0,    5'h1E),
      mk( 7, 0, 0,    0,0, 1,0, 0,  1,3, 0, 5'h1E,5'h1C), // R7 nmi with enable 0
      mk(10, 1, 5'h03,0,0, 0,0, 0,  0,0, 0, 0,    5'h03),
      mk( 8, 0, 0,    1,4, 1,1, 5,  1,3, 0, 5'h03,5'h00), // R8 all three
      mk(10, 1, 5'h03,0,0, 0,0, 0,  0,0, 0, 0,    5'h03),
      mk( 8, 0, 0,    1,6, 0,1,45,  1,2,45, 5'h03,5'h02), // R8 soft over mask
      mk(10, 1, 5'h07,0,0, 0,0, 0,  0,0, 0, 0,    5'h07),
      mk( 5, 0, 0,    1,7, 0,0, 0,  1,1, 7, 5'h07,5'h1C), // R5 top level
      mk(10, 1, 5'h1E,0,0, 0,0, 0,  0,0, 0, 0,    5'h1E),
      mk( 6, 0, 0,    0,0, 0,1,32,  1,2,32, 5'h1E,5'h1E), // R6 boundary 32
      mk( 9, 0, 0,    0,0, 0,0, 0,  0,0, 0, 0,    5'h1E), // R9 idle
      mk(10, 1, 5'h1F,0,0, 0,0, 0,  0,0, 0, 0,    5'h1F),
      mk( 3, 0, 0,    1,7, 0,0, 0,  0,0, 0, 0,    5'h1F)  // R3 level 7 held
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mask_req = 1'b0;
   logic [PRIO_W-1:0] mask_lvl = '0;
   logic              nmi_req = 1'b0;
   logic              soft_req = 1'b0;
   logic [NUM_W-1:0]  soft_num = '0;
   logic              restore_req = 1'b0;
   logic [FW-1:0]     restore_word = '0;
   logic              ack;
   logic [1:0]        ack_src;
   logic [NUM_W-1:0]  ack_num;
   logic [FW-1:0]     saved_flags;
   logic [FW-1:0]     flags;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_accept_ctrl #(.PRIO_W(PRIO_W), .NUM_W(NUM_W), .SW_LOW_LIMIT(32)) i_irq_accept_ctrl (
      .clk(clk), .rst_n(rst_n), .mask_req(mask_req), .mask_lvl(mask_lvl),
      .nmi_req(nmi_req), .soft_req(soft_req), .soft_num(soft_num),
      .restore_req(restore_req), .restore_word(restore_word),
      .ack(ack), .ack_src(ack_src), .ack_num(ack_num),
      .saved_flags(saved_flags), .flags(flags)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      mask_req = 1'b0; mask_lvl = '0; nmi_req = 1'b0; soft_req = 1'b0;
      soft_num = '0; restore_req = 1'b0; restore_word = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 flags in reset", int'(flags), 0);
      chk("R1 ack in reset", int'(ack), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flags after release", int'(flags), 0);

      for (int k = 0; k < NV; k++) begin
         vec_t v;
         string tg;
         v = TBL[k];
         restore_req = v.rv; restore_word = v.rw; mask_req = v.mr; mask_lvl = v.mp;
         nmi_req = v.nr; soft_req = v.sr; soft_num = v.sn;
         @(negedge clk);
         idle_inputs();
         tg = $sformatf("R%0d vec%0d", v.rq, k);
         chk({tg, " ack"}, int'(ack), int'(v.ea));
         chk({tg, " flags"}, int'(flags), int'(v.ef));
         if (v.ea) begin
            chk({tg, " src"}, int'(ack_src), int'(v.es));
            chk({tg, " num"}, int'(ack_num), int'(v.en));
            chk({tg, " saved"}, int'(saved_flags), int'(v.esv));
         end
      end

      // R9 latency: no ack before the edge that samples the request
      restore_req = 1'b1; restore_word = 5'h03;
      @(negedge clk);
      idle_inputs();
      soft_req = 1'b1; soft_num = 6'd2;
      #1;
      chk("R9 no ack before edge", int'(ack), 0);
      @(negedge clk);
      idle_inputs();
      chk("R9 ack after edge", int'(ack), 1);
      chk("R9 saved word", int'(saved_flags), 5'h03);
      @(negedge clk);
      chk("R9 ack is one cycle", int'(ack), 0);

      // R7 held non-maskable taken on consecutive cycles
      nmi_req = 1'b1;
      @(negedge clk);
      chk("R7 nmi first cycle", int'(ack), 1);
      @(negedge clk);
      chk("R7 nmi second cycle", int'(ack), 1);
      chk("R4 enable stays clear", int'(flags[0]), 0);
      idle_inputs();
      @(negedge clk);

      // R1 reset mid-run
      restore_req = 1'b1; restore_word = 5'h1F;
      @(negedge clk);
      idle_inputs();
      chk("R10 restore before reset", int'(flags), 5'h1F);
      rst_n = 1'b0;
      #1;
      chk("R1 flags after mid-run reset", int'(flags), 0);
      chk("R1 ack after mid-run reset", int'(ack), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule